// File: doc/BRIEF.md
# Prioritised interrupt request selector

This block makes the interrupt decision at each instruction boundary. Two sources compete. The first is a serial transmit-ready request. The second is an interval timer, built from a step counter with a programmable period. Each time the CPU signals a boundary on the step strobe, the block does four things:

- It advances the timer counter.
- It forms the candidate set from the two sources.
- It picks the candidate with the higher priority.
- It accepts that candidate only if the candidate's priority is strictly above the current mask, and only if no interrupt is already in service.

On acceptance, the block pulses `take` for one cycle and presents the vector-table entry address of the winning source. When the winner is the timer, it also pulses `timer_clr` to report that the timer counter has been cleared. The block does not stack the CPU state. On `take`, the CPU pushes the status word first and then the program counter. On return it pops them in the reverse order.

The timer counter is cleared only when the timer interrupt is actually taken. A timer request that is blocked by the in-service flag, by the mask, or by a winning serial request stays pending until the timer is granted.

Top module: `prio_irq_select`

## Requirements
- R1: After reset, `take` and `timer_clr` are 0, `vector` is 0 and the timer step count is zero.
- R2: A decision is made only on a clock edge where `step` is 1. Its result appears on `take`, `vector` and `timer_clr` on the following cycle. With `step` at 0, `take` stays 0.
- R3: A candidate is accepted only if its 3-bit priority is strictly greater than `sr_mask`. A priority equal to the mask is not accepted. If the higher-priority candidate fails this test, nothing is taken.
- R4: While `in_service` is 1, nothing is accepted. The timer counter keeps counting during this time.
- R5: When both sources request, the higher priority wins. The serial transmit vector is 16'h0084 and the timer vector is 16'h0042.
- R6: When both sources request with equal priority, the serial transmit source wins.
- R7: With period P, the timer first requests on the P-th step after its counter was cleared. The counter increments before the comparison.
- R8: The timer counter is cleared only when the timer interrupt is taken. A blocked timer request stays pending.
- R9: A period of 0 behaves as a period of 1, so the timer requests on every step.
- R10: `timer_clr` is 1 exactly when `take` is 1 with the timer vector. It is never 1 with the serial vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Instruction boundary strobe |
| tx_req | input | 1 | Serial transmit-ready request |
| tx_prio | input | PRIO_W | Serial source priority |
| tmr_prio | input | PRIO_W | Timer source priority |
| sr_mask | input | PRIO_W | Current interrupt mask from the status word |
| in_service | input | 1 | An interrupt handler is active |
| period | input | CNT_W | Timer period in steps (0 treated as 1) |
| take | output | 1 | One-cycle accept pulse |
| vector | output | ADDR_W | Vector-table entry of the accepted source |
| timer_clr | output | 1 | Timer counter cleared by this accept |

## Verification
The bench builds the block with an 8-bit counter (CNT_W = 8) and leaves the default vector addresses and 3-bit priorities unchanged. With the narrow counter, a full-scale period of 255 can be reached in a few hundred steps, so the exact first-request step and the saturation at the period can be checked at the top of the counter's range. The small periods used elsewhere (0, 1, 2 and 4) bring repeated timer grants, blocked-then-released requests and ties with the serial source into a short run.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [0:0] {
    SRC_TX  = 1'b0,
    SRC_TMR = 1'b1
  } irq_src_e;
endpackage

// File: rtl/irq_step_timer.sv
module irq_step_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [CNT_W-1:0] period,
  input  logic             clear,
  output logic             pending
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] per_eff;
  logic [CNT_W-1:0] cnt_inc;

  // A zero period behaves as one; the count saturates at the period.
  always_comb begin
    per_eff = (period == '0) ? CNT_W'(1) : period;
    cnt_inc = (cnt_q >= per_eff) ? cnt_q : cnt_q + CNT_W'(1);
    pending = (cnt_inc >= per_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= clear ? '0 : cnt_inc;
    end
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_sel_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic              tx_req,
  input  logic [PRIO_W-1:0] tx_prio,
  input  logic              tmr_req,
  input  logic [PRIO_W-1:0] tmr_prio,
  input  logic [PRIO_W-1:0] mask,
  input  logic              blocked,
  output logic              grant,
  output irq_src_e          src
);
  logic              tx_wins;
  logic [PRIO_W-1:0] win_prio;

  always_comb begin
    // Serial source wins ties.
    tx_wins  = tx_req && (!tmr_req || (tx_prio >= tmr_prio));
    src      = tx_wins ? SRC_TX : SRC_TMR;
    win_prio = tx_wins ? tx_prio : tmr_prio;
    grant    = (tx_req || tmr_req) && !blocked && (win_prio > mask);
  end
endmodule

// File: rtl/prio_irq_select.sv
module prio_irq_select
  import irq_sel_pkg::*;
#(
  parameter int               PRIO_W  = 3,
  parameter int               CNT_W   = 16,
  parameter int               ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_TX  = 16'h0084,
  parameter logic [ADDR_W-1:0] VEC_TMR = 16'h0042
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              tx_req,
  input  logic [PRIO_W-1:0] tx_prio,
  input  logic [PRIO_W-1:0] tmr_prio,
  input  logic [PRIO_W-1:0] sr_mask,
  input  logic              in_service,
  input  logic [CNT_W-1:0]  period,
  output logic              take,
  output logic [ADDR_W-1:0] vector,
  output logic              timer_clr
);
  logic     tmr_pend;
  logic     grant;
  irq_src_e src;
  logic     accept_now;
  logic     clr_now;

  assign accept_now = step && grant;
  assign clr_now    = accept_now && (src == SRC_TMR);

  irq_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .step    (step),
    .period  (period),
    .clear   (clr_now),
    .pending (tmr_pend)
  );

  irq_prio_arbiter #(.PRIO_W(PRIO_W)) u_arb (
    .tx_req   (tx_req),
    .tx_prio  (tx_prio),
    .tmr_req  (tmr_pend),
    .tmr_prio (tmr_prio),
    .mask     (sr_mask),
    .blocked  (in_service),
    .grant    (grant),
    .src      (src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take      <= 1'b0;
      timer_clr <= 1'b0;
      vector    <= '0;
    end else begin
      take      <= accept_now;
      timer_clr <= clr_now;
      if (accept_now) begin
        vector <= (src == SRC_TMR) ? VEC_TMR : VEC_TX;
      end
    end
  end
endmodule

// File: rtl/prio_irq_select_chk.sv
module prio_irq_select_chk #(
  parameter int               PRIO_W  = 3,
  parameter int               ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_TX  = 16'h0084,
  parameter logic [ADDR_W-1:0] VEC_TMR = 16'h0042
) (
  input logic              clk,
  input logic              rst,
  input logic              step,
  input logic              tx_req,
  input logic [PRIO_W-1:0] tx_prio,
  input logic [PRIO_W-1:0] tmr_prio,
  input logic [PRIO_W-1:0] sr_mask,
  input logic              in_service,
  input logic              take,
  input logic [ADDR_W-1:0] vector,
  input logic              timer_clr
);
  a_r2_take_needs_step: assert property (@(posedge clk) disable iff (rst)
    take |-> $past(step));

  a_r4_blocked_in_service: assert property (@(posedge clk) disable iff (rst)
    take |-> !$past(in_service));

  a_r3_tx_above_mask: assert property (@(posedge clk) disable iff (rst)
    (take && vector == VEC_TX) |-> ($past(tx_prio) > $past(sr_mask)));

  a_r3_tmr_above_mask: assert property (@(posedge clk) disable iff (rst)
    (take && vector == VEC_TMR) |-> ($past(tmr_prio) > $past(sr_mask)));

  a_r5_tx_requested: assert property (@(posedge clk) disable iff (rst)
    (take && vector == VEC_TX) |-> $past(tx_req));

  a_r10_clr_means_timer: assert property (@(posedge clk) disable iff (rst)
    timer_clr |-> (take && vector == VEC_TMR));

  a_r10_timer_take_clears: assert property (@(posedge clk) disable iff (rst)
    (take && vector == VEC_TMR) |-> timer_clr);
endmodule

bind prio_irq_select prio_irq_select_chk #(
  .PRIO_W (PRIO_W),
  .ADDR_W (ADDR_W),
  .VEC_TX (VEC_TX),
  .VEC_TMR(VEC_TMR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .step       (step),
  .tx_req     (tx_req),
  .tx_prio    (tx_prio),
  .tmr_prio   (tmr_prio),
  .sr_mask    (sr_mask),
  .in_service (in_service),
  .take       (take),
  .vector     (vector),
  .timer_clr  (timer_clr)
);

// File: tb/tb_prio_irq_select.sv
module tb_prio_irq_select;
  localparam int CNT_W = 8;
  localparam logic [15:0] VTX  = 16'h0084;
  localparam logic [15:0] VTMR = 16'h0042;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             step = 1'b0;
  logic             tx_req = 1'b0;
  logic [2:0]       tx_prio = '0;
  logic [2:0]       tmr_prio = '0;
  logic [2:0]       sr_mask = '0;
  logic             in_service = 1'b0;
  logic [CNT_W-1:0] period = '0;
  logic             take;
  logic [15:0]      vector;
  logic             timer_clr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  prio_irq_select #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .step(step), .tx_req(tx_req), .tx_prio(tx_prio),
    .tmr_prio(tmr_prio), .sr_mask(sr_mask), .in_service(in_service),
    .period(period), .take(take), .vector(vector), .timer_clr(timer_clr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; step = 1'b0; tx_req = 1'b0; tx_prio = '0; tmr_prio = '0;
    sr_mask = '0; in_service = 1'b0; period = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // One step; outputs sampled one time unit after the edge that registers them.
  task automatic step_expect(input bit s, input bit exp_take,
                             input logic [15:0] exp_vec, input string req);
    @(negedge clk);
    step = s;
    @(posedge clk);
    #1;
    step = 1'b0;
    chk(take == exp_take, req, "take", int'(take), int'(exp_take));
    if (exp_take) begin
      chk(vector == exp_vec, req, "vector", int'(vector), int'(exp_vec));
      chk(timer_clr == (exp_vec == VTMR), "R10", "timer_clr",
          int'(timer_clr), int'(exp_vec == VTMR));
    end else begin
      chk(timer_clr == 1'b0, "R10", "timer_clr idle", int'(timer_clr), 0);
    end
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk(take == 1'b0, "R1", "take", int'(take), 0);
    chk(timer_clr == 1'b0, "R1", "timer_clr", int'(timer_clr), 0);
    chk(vector == 16'h0, "R1", "vector", int'(vector), 0);
    // Zero count after reset: period 3 fires on the third step only.
    period = 3; tmr_prio = 1;
    step_expect(1, 0, VTMR, "R1");
    step_expect(1, 0, VTMR, "R1");
    step_expect(1, 1, VTMR, "R1");
  endtask

  task automatic t_tx_mask();
    do_reset();
    tx_req = 1; tx_prio = 5; sr_mask = 4;
    step_expect(1, 1, VTX, "R5");
    sr_mask = 5;
    step_expect(1, 0, VTX, "R3");
    sr_mask = 6;
    step_expect(1, 0, VTX, "R3");
  endtask

  task automatic t_timer_period();
    do_reset();
    period = 4; tmr_prio = 3;
    for (int k = 1; k <= 8; k++)
      step_expect(1, (k % 4) == 0, VTMR, "R7");
  endtask

  task automatic t_in_service();
    do_reset();
    period = 2; tmr_prio = 2; in_service = 1; tx_req = 1; tx_prio = 7;
    for (int k = 0; k < 5; k++) step_expect(1, 0, VTMR, "R4");
    tx_req = 0; in_service = 0;
    step_expect(1, 1, VTMR, "R8");
    step_expect(1, 0, VTMR, "R8");
    step_expect(1, 1, VTMR, "R8");
  endtask

  task automatic t_priority();
    do_reset();
    period = 1; tx_req = 1; tx_prio = 2; tmr_prio = 6;
    step_expect(1, 1, VTMR, "R5");
    tx_prio = 6; tmr_prio = 2;
    step_expect(1, 1, VTX, "R5");
    tx_prio = 4; tmr_prio = 4;
    step_expect(1, 1, VTX, "R6");
    tx_req = 0;
    step_expect(1, 1, VTMR, "R8");
  endtask

  task automatic t_period_zero();
    do_reset();
    period = 0; tmr_prio = 1;
    for (int k = 0; k < 3; k++) step_expect(1, 1, VTMR, "R9");
  endtask

  task automatic t_mask_timer();
    do_reset();
    period = 1; tmr_prio = 3; sr_mask = 3;
    step_expect(1, 0, VTMR, "R3");
    tx_req = 1; tx_prio = 5; tmr_prio = 6; sr_mask = 6;
    step_expect(1, 0, VTMR, "R3");
    tx_req = 0; sr_mask = 2;
    step_expect(1, 1, VTMR, "R3");
  endtask

  task automatic t_no_strobe();
    do_reset();
    period = 1; tmr_prio = 7; tx_req = 1; tx_prio = 7;
    for (int k = 0; k < 4; k++) step_expect(0, 0, VTX, "R2");
    step_expect(1, 1, VTX, "R2");
  endtask

  task automatic t_full_period();
    do_reset();
    period = 255; tmr_prio = 1;
    for (int k = 1; k < 255; k++) step_expect(1, 0, VTMR, "R7");
    step_expect(1, 1, VTMR, "R7");
    step_expect(1, 0, VTMR, "R8");
  endtask

  initial begin
    #100000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_tx_mask();
    t_timer_period();
    t_in_service();
    t_priority();
    t_period_zero();
    t_mask_timer();
    t_no_strobe();
    t_full_period();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule